// File: doc/BRIEF.md
# Second-Order IIR Filter Section

This block is one second-order recursive filter stage. It takes one signed audio sample on each cycle where `in_valid` is high. It multiplies the current input, the two previous inputs and the two previous outputs by five programmable coefficients and sums the products at full width. It then rounds the sum once and clips it to the signed 3.23 data range. The result appears on `out_sample`, with `out_valid` high, on the following clock cycle.

The feedback products are added in the recurrence, not subtracted: y[n] = b0·x[n] + b1·x[n−1] + b2·x[n−2] + a1·y[n−1] + a2·y[n−2]. The parameter `WIDE_IN` sets the input format. At 0 the input is a 24-bit 1.23 word, which the block widens to 26 bits by sign extension. At 1 the input is already a 26-bit 3.23 word.

Coefficients are loaded one at a time into shadow registers. A commit pulse then copies all five into the working set at once, between samples. No sample ever sees a mix of old and new values.

Top module: `biquad_section`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_sample` is 0. The working and shadow coefficient sets both hold the pass-through setting (b0 = 1.0, i.e. 0x100000; all others 0). The delay state is zero.
- R2: With `WIDE_IN`=0, a 24-bit input word x is treated as the signed value x/2^23. It is sign-extended by two bits into the 26-bit 3.23 data word.
- R3: Each output follows y[n] = b0·x[n] + b1·x[n−1] + b2·x[n−2] + a1·y[n−1] + a2·y[n−2], with the a-terms added.
- R4: Coefficients are signed 22-bit words with 20 fraction bits. `coef_sel` picks the shadow slot: 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2. A write with `coef_sel` of 5, 6 or 7 changes no slot.
- R5: The five 48-bit products are summed without loss. The sum is rounded once, by adding 2^19 and shifting right arithmetically by 20 bits, to 23 fraction bits.
- R6: A rounded sum above 2^25−1 gives 0x1FFFFFF. A sum below −2^25 gives 0x2000000. The result never wraps.
- R7: The delay state holds the two previous extended inputs and the two previous clipped outputs. It advances only on cycles where `in_valid` is high.
- R8: A shadow write has no effect on outputs until `coef_commit` is pulsed. The commit moves all five shadow values into the working set at one clock edge.
- R9: `out_valid` is high exactly in the cycle after each cycle where `in_valid` is high. `out_sample` holds its value otherwise.
- R10: With the pass-through setting, `out_sample` equals the extended input exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 (26 if WIDE_IN) | Signed input sample |
| coef_wr | input | 1 | Write `coef_data` into the shadow slot `coef_sel` |
| coef_sel | input | 3 | Shadow slot index |
| coef_data | input | 22 | Signed 2.20 coefficient |
| coef_commit | input | 1 | Copy the whole shadow set into the working set |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 26 | Clipped 3.23 output sample |

## Verification
The assertions assume that reset is held for at least one clock edge before any strobe. They also assume that `in_valid`, `coef_wr` and `coef_commit` are clean single-cycle levels sampled at the rising edge.

The stimulus changes every input only on the falling edge. Reset stays high for several cycles with every strobe low. Each sample is followed by an idle cycle, and commits are never issued in the same cycle as a sample. This keeps the latency and stability properties inside the conditions they assume.

The filter sweeps use coefficients inside the 2.20 range. Long feedback runs deliberately drive the sum past both ends of the data range, so that clipping is exercised.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
    localparam int COEF_W    = 22;
    localparam int COEF_FRAC = 20;
    localparam int DATA_W    = 26;
    localparam int NARROW_W  = 24;
    localparam int NUM_TAPS  = 5;
    localparam int ACC_W     = COEF_W + DATA_W + $clog2(NUM_TAPS);

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [DATA_W-1:0] data_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [2:0] {
        SEL_B0 = 3'd0,
        SEL_B1 = 3'd1,
        SEL_B2 = 3'd2,
        SEL_A1 = 3'd3,
        SEL_A2 = 3'd4
    } coef_sel_e;

    typedef struct packed {
        coef_t b0;
        coef_t b1;
        coef_t b2;
        coef_t a1;
        coef_t a2;
    } coef_set_t;

    localparam coef_t     COEF_ONE  = coef_t'(1) << COEF_FRAC;
    localparam coef_set_t COEF_PASS = '{b0: COEF_ONE, default: '0};

    localparam acc_t DATA_MAX = acc_t'({1'b0, {(DATA_W-1){1'b1}}});
    localparam acc_t DATA_MIN = -DATA_MAX - acc_t'(1);

    function automatic data_t clip_to_data(acc_t v);
        if (v > DATA_MAX)      return {1'b0, {(DATA_W-1){1'b1}}};
        else if (v < DATA_MIN) return {1'b1, {(DATA_W-1){1'b0}}};
        else                   return data_t'(v);
    endfunction
endpackage

// File: rtl/biquad_coef_bank.sv
module biquad_coef_bank
    import biquad_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [2:0] sel,
    input  coef_t     wdata,
    input  logic      commit,
    output coef_set_t active
);
    coef_set_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= COEF_PASS;
        end else if (wr) begin
            case (sel)
                SEL_B0:  shadow.b0 <= wdata;
                SEL_B1:  shadow.b1 <= wdata;
                SEL_B2:  shadow.b2 <= wdata;
                SEL_A1:  shadow.a1 <= wdata;
                SEL_A2:  shadow.a2 <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         active <= COEF_PASS;
        else if (commit) active <= shadow;
    end

    // R8
    hold_without_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active));

    // R8
    commit_copies_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> active == $past(shadow));
endmodule

// File: rtl/biquad_delay_line.sv
module biquad_delay_line
    import biquad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  data_t x_new,
    input  data_t y_new,
    output data_t x1,
    output data_t x2,
    output data_t y1,
    output data_t y2
);
    always_ff @(posedge clk) begin
        if (rst) begin
            x1 <= '0;
            x2 <= '0;
            y1 <= '0;
            y2 <= '0;
        end else if (adv) begin
            x1 <= x_new;
            x2 <= x1;
            y1 <= y_new;
            y2 <= y1;
        end
    end

    // R7
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable({x1, x2, y1, y2}));

    // R7
    state_shift_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (x2 == $past(x1)) && (y2 == $past(y1)) && (y1 == $past(y_new)));
endmodule

// File: rtl/biquad_mac.sv
module biquad_mac
    import biquad_pkg::*;
(
    input  coef_set_t coefs,
    input  data_t     x0,
    input  data_t     x1,
    input  data_t     x2,
    input  data_t     y1,
    input  data_t     y2,
    output data_t     y
);
    localparam acc_t RND_HALF = acc_t'(1) << (COEF_FRAC - 1);

    coef_t c [NUM_TAPS];
    data_t d [NUM_TAPS];
    acc_t  prod [NUM_TAPS];
    acc_t  sum;
    acc_t  rounded;

    assign c[0] = coefs.b0;
    assign c[1] = coefs.b1;
    assign c[2] = coefs.b2;
    assign c[3] = coefs.a1;
    assign c[4] = coefs.a2;
    assign d[0] = x0;
    assign d[1] = x1;
    assign d[2] = x2;
    assign d[3] = y1;
    assign d[4] = y2;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign prod[i] = acc_t'($signed(c[i])) * acc_t'($signed(d[i]));
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < NUM_TAPS; i++) sum = sum + prod[i];
        rounded = (sum + RND_HALF) >>> COEF_FRAC;
        y = clip_to_data(rounded);
    end
endmodule

// File: rtl/biquad_section.sv
module biquad_section
    import biquad_pkg::*;
#(
    parameter bit WIDE_IN = 1'b0,
    localparam int IN_W   = WIDE_IN ? DATA_W : NARROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_sample,
    input  logic              coef_wr,
    input  logic [2:0]        coef_sel,
    input  logic [COEF_W-1:0] coef_data,
    input  logic              coef_commit,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    data_t     x_ext;
    data_t     x1, x2, y1, y2;
    data_t     y_next;
    coef_set_t act;

    if (WIDE_IN) begin : g_wide
        assign x_ext = data_t'($signed(in_sample));
    end else begin : g_narrow
        assign x_ext = data_t'($signed(in_sample));
    end

    biquad_coef_bank u_coefs (
        .clk    (clk),
        .rst    (rst),
        .wr     (coef_wr),
        .sel    (coef_sel),
        .wdata  (coef_t'(coef_data)),
        .commit (coef_commit),
        .active (act)
    );

    biquad_delay_line u_state (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_valid),
        .x_new (x_ext),
        .y_new (y_next),
        .x1    (x1),
        .x2    (x2),
        .y1    (y1),
        .y2    (y2)
    );

    biquad_mac u_mac (
        .coefs (act),
        .x0    (x_ext),
        .x1    (x1),
        .x2    (x2),
        .y1    (y1),
        .y2    (y2),
        .y     (y_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= y_next;
        end
    end

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(out_sample));

    // R10
    passthrough_exact_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && act == COEF_PASS) |=> out_sample == $past(x_ext));

    // R6
    state_matches_out_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> y1 == data_t'(out_sample));
endmodule

// File: tb/biquad_section_test.sv
module biquad_section_test;
    localparam int CLK_PERIOD = 10;
    localparam longint SAT_HI = (64'sd1 <<< 25) - 1;
    localparam longint SAT_LO = -(64'sd1 <<< 25);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_sample = '0;
    logic        coef_wr = 1'b0;
    logic [2:0]  coef_sel = '0;
    logic [21:0] coef_data = '0;
    logic        coef_commit = 1'b0;
    logic        out_valid;
    logic [25:0] out_sample;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    longint sh [5];
    longint ac [5];
    longint mx1, mx2, my1, my2;

    biquad_section uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .coef_wr(coef_wr), .coef_sel(coef_sel), .coef_data(coef_data),
        .coef_commit(coef_commit), .out_valid(out_valid), .out_sample(out_sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_step(longint x);
        longint s, r;
        s = ac[0]*x + ac[1]*mx1 + ac[2]*mx2 + ac[3]*my1 + ac[4]*my2;
        r = (s + (64'sd1 <<< 19)) >>> 20;
        if (r > SAT_HI) r = SAT_HI;
        if (r < SAT_LO) r = SAT_LO;
        mx2 = mx1; mx1 = x; my2 = my1; my1 = r;
        return r;
    endfunction

    task automatic wr_coef(int sel, longint v);
        @(negedge clk);
        coef_wr = 1'b1; coef_sel = 3'(sel); coef_data = 22'(v);
        if (sel < 5) sh[sel] = v;
        @(negedge clk);
        coef_wr = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        coef_commit = 1'b1;
        for (int i = 0; i < 5; i++) ac[i] = sh[i];
        @(negedge clk);
        coef_commit = 1'b0;
    endtask

    task automatic send(longint x, string req);
        longint exp;
        @(negedge clk);
        in_valid = 1'b1; in_sample = 24'(x);
        exp = model_step(x);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", longint'(out_valid), 1);
        check(req, longint'($signed(out_sample)), exp);
        @(negedge clk);
        check("R9", longint'(out_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint lfsr;
        sh = '{64'sd1 <<< 20, 0, 0, 0, 0};
        ac = sh;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", longint'(out_valid), 0);
        check("R1", longint'($signed(out_sample)), 0);
        rst = 1'b0;

        // R10 R2 R1: pass-through sweep including both 24-bit extremes
        send(64'sd8388607, "R10");
        send(-64'sd8388608, "R2");
        send(-1, "R2");
        for (int i = 0; i < 64; i++) send(longint'(i) * 262143 - 64'sd8388608, "R10");

        // R8: shadow write alone must not alter output
        wr_coef(0, 64'sd1 <<< 19);
        send(64'sd4000000, "R8");
        send(-64'sd1234567, "R8");
        commit();
        send(64'sd4000000, "R8");

        // R4: out-of-range select ignored after commit
        wr_coef(7, 22'h155555);
        wr_coef(5, -64'sd1);
        commit();
        send(64'sd3000001, "R4");

        // R3 R5 R7: general filter, odd coefficients, idle gaps
        wr_coef(0, 262145);
        wr_coef(1, 524287);
        wr_coef(2, 262143);
        wr_coef(3, 629146);
        wr_coef(4, -314573);
        commit();
        lfsr = 12345;
        for (int i = 0; i < 150; i++) begin
            lfsr = (lfsr * 1103515245 + 12345) & 64'hFFFFFF;
            send(lfsr - 64'sd8388608, (i % 2 == 0) ? "R3" : "R5");
            if (i % 3 == 0) repeat (2) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        send(64'sd777, "R7");

        // R6: integrator y = x + y1 driven to both rails
        wr_coef(0, 64'sd1 <<< 20);
        wr_coef(1, 0);
        wr_coef(2, 0);
        wr_coef(3, 64'sd1 <<< 20);
        wr_coef(4, 0);
        commit();
        for (int i = 0; i < 8; i++) send(64'sd8388607, "R6");
        check("R6", longint'($signed(out_sample)), SAT_HI);
        for (int i = 0; i < 16; i++) send(-64'sd8388608, "R6");
        check("R6", longint'($signed(out_sample)), SAT_LO);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule